// File: doc/BRIEF.md
# SPI Command Segment Sequencer

This block runs one SPI segment per accepted command. A command word carries a byte count; the sequencer then repeats a fixed loop until the count is used up: take one byte from the transmit byte FIFO, hand it to an external serial shifter and wait for the shifter to finish, then push the byte the shifter returns into the receive byte FIFO. Clock division, chip-select lead and trail timing, and multi-lane speeds are handled elsewhere. The shifter only sees a byte request and acknowledge pair.

The block also holds the global enable, the chip-select index and the software reset. A command that arrives while a segment is still running is refused, and an error pulse goes to the interrupt logic. A chip-select index outside the configured range is refused in the same way. If a FIFO cannot feed or accept a byte, the segment stops early and a sticky stall flag is set. When a segment ends, the transmit FIFO is told to drop whatever is left in it.

Top module: `spi_seg_sequencer`

## Requirements
- R1: Each byte popped from the TX FIFO is presented on `xchg_tx` with `xchg_req` held high until `xchg_ack`. The `xchg_rx` value on the acknowledge cycle is pushed into the RX FIFO, and bytes keep their order.
- R2: Register writes select a target with `reg_wr_sel` (0 = command, 1 = chip-select index, 2 = control). A command write is ignored when the enable bit (bit 31 of control) is clear: `ready` stays high, no byte is popped and no error is raised.
- R3: An accepted command with a nonzero length (bits 7:0 of the command word) makes `ready` low and `active` high from the next cycle. `active` stays high until the last exchange is acknowledged. `ready` and `active` are never both high.
- R4: A segment moves exactly the commanded number of bytes when the FIFOs allow it. `ready` then returns high.
- R5: A command written while enabled and `ready` is low produces a one-cycle `err_cmdbusy` pulse in the next cycle. The running segment is unaffected.
- R6: When a segment ends, `tx_flush` pulses for one cycle, so bytes left in the TX FIFO are discarded.
- R7: If the TX FIFO is empty when a byte is due, the segment ends, `tx_stall` goes high and `ready` returns.
- R8: If the RX FIFO is full when a byte is due (and TX has data), the segment ends, `rx_stall` goes high and `ready` returns.
- R9: A length of zero exchanges no bytes. `active` stays low and `ready` is high again two cycles after the write.
- R10: Writing a chip-select index greater than or equal to `NUM_CS` pulses `err_csidinval` in the next cycle and leaves `csid` unchanged. A valid index is stored.
- R11: A control write with bit 30 set returns the block to idle (`ready` high, `active` low), clears `spi_en`, `csid` and the stall flags, and pulses both `tx_flush` and `rx_flush` in the next cycle.
- R12: After reset, `ready` is high, and `active`, the stall flags, `spi_en`, `csid` and both error pulses are low.
- R13: Accepting a new command clears both stall flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 command, 1 chip-select index, 2 control |
| reg_wr_data | input | 32 | Write data |
| tx_empty | input | 1 | TX FIFO has no byte |
| tx_byte | input | 8 | TX FIFO head byte (show-ahead) |
| tx_pop | output | 1 | Consume TX head byte |
| tx_flush | output | 1 | Discard all TX FIFO contents |
| rx_full | input | 1 | RX FIFO cannot accept a byte |
| rx_push | output | 1 | Write `rx_byte` into RX FIFO |
| rx_byte | output | 8 | Byte returned by the shifter |
| rx_flush | output | 1 | Discard all RX FIFO contents |
| xchg_req | output | 1 | Byte exchange request to the shifter |
| xchg_tx | output | 8 | Byte to shift out |
| xchg_ack | input | 1 | Exchange finished |
| xchg_rx | input | 8 | Byte shifted in |
| ready | output | 1 | Idle, able to take a command |
| active | output | 1 | Segment moving bytes |
| tx_stall | output | 1 | Last segment stopped on empty TX FIFO |
| rx_stall | output | 1 | Last segment stopped on full RX FIFO |
| spi_en | output | 1 | Global enable |
| csid | output | CSW | Selected chip-select index |
| err_cmdbusy | output | 1 | Command refused because a segment was running |
| err_csidinval | output | 1 | Chip-select index refused |

## Verification
The bench builds the block with `NUM_CS = 3`. At that value the 2-bit index field can encode 3, and 3 is out of range, so the range check is tested against a value the stored field could actually hold. The bench models the FIFOs with an RX depth of 4, which makes the full-RX stall reachable within a few bytes. The bench shifter has an adjustable acknowledge latency. A slow latency keeps a segment running long enough for a second command to be refused and for a software reset to hit mid-exchange.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XCHG  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam int          BYTE_W       = 8;
  localparam int          LEN_W        = 8;
  localparam logic [1:0]  SEL_CMD      = 2'd0;
  localparam logic [1:0]  SEL_CSID     = 2'd1;
  localparam logic [1:0]  SEL_CTRL     = 2'd2;
  localparam int          CTRL_EN_BIT  = 31;
  localparam int          CTRL_RST_BIT = 30;

  function automatic logic [LEN_W-1:0] seg_len_of(input logic [31:0] word);
    return word[LEN_W-1:0];
  endfunction

  function automatic logic csid_in_range(input logic [31:0] idx, input int unsigned ncs);
    return idx < 32'(ncs);
  endfunction

  function automatic logic is_last_byte(input logic [LEN_W-1:0] remain);
    return remain == LEN_W'(1);
  endfunction

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [31:0]    wr_data,
  input  logic           eng_ready,
  output logic           spi_en,
  output logic [CSW-1:0] csid,
  output logic           cmd_go,
  output logic           sw_rst,
  output logic           fifo_clr,
  output logic           err_cmdbusy,
  output logic           err_csidinval
);

  logic cmd_wr, csid_wr, ctrl_wr, busy_hit, csid_ok;

  assign cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  assign csid_wr  = wr_en && (wr_sel == SEL_CSID);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign cmd_go   = cmd_wr && spi_en && eng_ready;
  assign busy_hit = cmd_wr && spi_en && !eng_ready;
  assign sw_rst   = ctrl_wr && wr_data[CTRL_RST_BIT];
  assign csid_ok  = csid_in_range(wr_data, NUM_CS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_en        <= 1'b0;
      csid          <= '0;
      fifo_clr      <= 1'b0;
      err_cmdbusy   <= 1'b0;
      err_csidinval <= 1'b0;
    end else begin
      fifo_clr      <= sw_rst;
      err_cmdbusy   <= busy_hit;
      err_csidinval <= csid_wr && !csid_ok;
      if (sw_rst) begin
        spi_en <= 1'b0;
        csid   <= '0;
      end else begin
        if (ctrl_wr) spi_en <= wr_data[CTRL_EN_BIT];
        if (csid_wr && csid_ok) csid <= wr_data[CSW-1:0];
      end
    end
  end

endmodule

// File: rtl/seg_byte_engine.sv
module seg_byte_engine
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              abort,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_full,
  input  logic              xchg_ack,
  input  logic [BYTE_W-1:0] xchg_rx,
  output logic              ready,
  output logic              active,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              xchg_req,
  output logic [BYTE_W-1:0] xchg_tx,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic              seg_flush
);

  seq_state_e        state;
  logic [LEN_W-1:0]  remain;
  logic [BYTE_W-1:0] shreg;
  logic              byte_ok;

  assign byte_ok   = !tx_empty && !rx_full;
  assign ready     = (state == ST_IDLE);
  assign active    = (state == ST_FETCH) || (state == ST_XCHG);
  assign tx_pop    = (state == ST_FETCH) && byte_ok;
  assign xchg_req  = (state == ST_XCHG);
  assign xchg_tx   = shreg;
  assign rx_push   = xchg_req && xchg_ack;
  assign rx_byte   = xchg_rx;
  assign seg_flush = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      shreg    <= '0;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else if (abort) begin
      state    <= ST_IDLE;
      remain   <= '0;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_go) begin
          tx_stall <= 1'b0;
          rx_stall <= 1'b0;
          remain   <= cmd_len;
          state    <= (cmd_len == '0) ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: begin
          if (tx_empty) begin
            tx_stall <= 1'b1;
            state    <= ST_DONE;
          end else if (rx_full) begin
            rx_stall <= 1'b1;
            state    <= ST_DONE;
          end else begin
            shreg <= tx_byte;
            state <= ST_XCHG;
          end
        end
        ST_XCHG: if (xchg_ack) begin
          remain <= remain - LEN_W'(1);
          state  <= is_last_byte(remain) ? ST_DONE : ST_FETCH;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_seg_sequencer.sv
module spi_seg_sequencer
  import spi_seq_pkg::*;
#(
  parameter  int NUM_CS = 4,
  localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [1:0]     reg_wr_sel,
  input  logic [31:0]    reg_wr_data,
  input  logic           tx_empty,
  input  logic [7:0]     tx_byte,
  output logic           tx_pop,
  output logic           tx_flush,
  input  logic           rx_full,
  output logic           rx_push,
  output logic [7:0]     rx_byte,
  output logic           rx_flush,
  output logic           xchg_req,
  output logic [7:0]     xchg_tx,
  input  logic           xchg_ack,
  input  logic [7:0]     xchg_rx,
  output logic           ready,
  output logic           active,
  output logic           tx_stall,
  output logic           rx_stall,
  output logic           spi_en,
  output logic [CSW-1:0] csid,
  output logic           err_cmdbusy,
  output logic           err_csidinval
);

  logic cmd_go, sw_rst, fifo_clr, seg_flush;

  seg_cfg_regs #(.NUM_CS(NUM_CS), .CSW(CSW)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_wr_en),
    .wr_sel       (reg_wr_sel),
    .wr_data      (reg_wr_data),
    .eng_ready    (ready),
    .spi_en       (spi_en),
    .csid         (csid),
    .cmd_go       (cmd_go),
    .sw_rst       (sw_rst),
    .fifo_clr     (fifo_clr),
    .err_cmdbusy  (err_cmdbusy),
    .err_csidinval(err_csidinval)
  );

  seg_byte_engine eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .cmd_len  (seg_len_of(reg_wr_data)),
    .abort    (sw_rst),
    .tx_empty (tx_empty),
    .tx_byte  (tx_byte),
    .rx_full  (rx_full),
    .xchg_ack (xchg_ack),
    .xchg_rx  (xchg_rx),
    .ready    (ready),
    .active   (active),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .rx_byte  (rx_byte),
    .xchg_req (xchg_req),
    .xchg_tx  (xchg_tx),
    .tx_stall (tx_stall),
    .rx_stall (rx_stall),
    .seg_flush(seg_flush)
  );

  assign tx_flush = seg_flush || fifo_clr;
  assign rx_flush = fifo_clr;

endmodule

// File: rtl/spi_seg_sequencer_chk.sv
module spi_seg_sequencer_chk #(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr_en,
  input logic [1:0]     reg_wr_sel,
  input logic [31:0]    reg_wr_data,
  input logic           tx_empty,
  input logic           rx_full,
  input logic           tx_pop,
  input logic           tx_flush,
  input logic           rx_push,
  input logic           rx_flush,
  input logic           xchg_req,
  input logic [7:0]     xchg_tx,
  input logic           xchg_ack,
  input logic           ready,
  input logic           active,
  input logic           spi_en,
  input logic [CSW-1:0] csid,
  input logic           err_cmdbusy,
  input logic           err_csidinval
);

  logic cmd_w, csid_w, rst_w;
  assign cmd_w  = reg_wr_en && (reg_wr_sel == 2'd0);
  assign csid_w = reg_wr_en && (reg_wr_sel == 2'd1);
  assign rst_w  = reg_wr_en && (reg_wr_sel == 2'd2) && reg_wr_data[30];

  AST_READY_ACTIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && active)); // R3

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && !spi_en && ready |=> ready && !err_cmdbusy); // R2

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && spi_en && ready && (reg_wr_data[7:0] != 8'd0) |=> !ready && active); // R3

  AST_ZERO_LEN_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && spi_en && ready && (reg_wr_data[7:0] == 8'd0) |=> !active && !tx_pop); // R9

  AST_BUSY_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && spi_en && !ready |=> err_cmdbusy); // R5

  AST_POP_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty && !rx_full); // R7

  AST_PUSH_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> xchg_req && xchg_ack); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_req && !xchg_ack && !rst_w |=> xchg_req && $stable(xchg_tx)); // R1

  AST_CSID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    csid_w && (reg_wr_data >= 32'(NUM_CS)) |=> err_csidinval && $stable(csid)); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_w |=> ready && !active && !spi_en && (csid == '0) && tx_flush && rx_flush); // R11

endmodule

bind spi_seg_sequencer spi_seg_sequencer_chk #(.NUM_CS(NUM_CS), .CSW(CSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .reg_wr_data(reg_wr_data), .tx_empty(tx_empty), .rx_full(rx_full), .tx_pop(tx_pop),
  .tx_flush(tx_flush), .rx_push(rx_push), .rx_flush(rx_flush), .xchg_req(xchg_req),
  .xchg_tx(xchg_tx), .xchg_ack(xchg_ack), .ready(ready), .active(active),
  .spi_en(spi_en), .csid(csid), .err_cmdbusy(err_cmdbusy), .err_csidinval(err_csidinval)
);

// File: tb/spi_seg_sequencer_tb_top.sv
module spi_seg_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCS        = 3;
  localparam int RXD        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic        tx_empty, rx_full, tx_pop, tx_flush, rx_push, rx_flush;
  logic [7:0]  tx_byte, rx_byte, xchg_tx;
  logic        xchg_req;
  logic        xchg_ack = 1'b0;
  logic [7:0]  xchg_rx = '0;
  logic        ready, active, tx_stall, rx_stall, spi_en;
  logic [1:0]  csid;
  logic        err_cmdbusy, err_csidinval;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_seg_sequencer #(.NUM_CS(NCS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .tx_empty(tx_empty), .tx_byte(tx_byte), .tx_pop(tx_pop),
    .tx_flush(tx_flush), .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_flush(rx_flush), .xchg_req(xchg_req), .xchg_tx(xchg_tx), .xchg_ack(xchg_ack),
    .xchg_rx(xchg_rx), .ready(ready), .active(active), .tx_stall(tx_stall),
    .rx_stall(rx_stall), .spi_en(spi_en), .csid(csid), .err_cmdbusy(err_cmdbusy),
    .err_csidinval(err_csidinval)
  );

  // Bench FIFO models: tx writes from tasks at negedge, reads at posedge.
  logic [7:0] txmem [16];
  logic [7:0] rxmem [16];
  int txw = 0, txr = 0, rxw = 0, rxr = 0;
  logic tx_clr_req = 1'b0, rx_clr_req = 1'b0, rx_fill_req = 1'b0;
  int lat = 1, wcnt = 0;

  assign tx_empty = (txw == txr);
  assign tx_byte  = txmem[txr[3:0]];
  assign rx_full  = ((rxw - rxr) >= RXD);

  always @(posedge clk) begin
    if (tx_flush || tx_clr_req) txr <= txw;
    else if (tx_pop) txr <= txr + 1;
    if (rx_flush || rx_clr_req) rxr <= rxw;
    if (rx_fill_req) rxw <= rxw + 2;
    else if (rx_push) begin
      rxmem[rxw[3:0]] <= rx_byte;
      rxw <= rxw + 1;
    end
    if (xchg_req && !xchg_ack) begin
      if (wcnt >= lat) begin
        xchg_ack <= 1'b1;
        xchg_rx  <= xchg_tx ^ 8'hA5;
        wcnt     <= 0;
      end else wcnt <= wcnt + 1;
    end else begin
      xchg_ack <= 1'b0;
    end
  end

  int nchk = 0, nbad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    txmem[txw[3:0]] = b;
    txw = txw + 1;
  endtask

  task automatic clear_fifos();
    @(negedge clk);
    tx_clr_req = 1'b1; rx_clr_req = 1'b1;
    @(negedge clk);
    tx_clr_req = 1'b0; rx_clr_req = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      if (ready) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R12 ready", int'(ready), 1);
    chk("R12 active", int'(active), 0);
    chk("R12 stalls", int'({tx_stall, rx_stall}), 0);
    chk("R12 spi_en", int'(spi_en), 0);
    chk("R12 csid", int'(csid), 0);
    chk("R12 errors", int'({err_cmdbusy, err_csidinval}), 0);
  endtask

  task automatic t_disabled();
    clear_fifos();
    push_tx(8'h10); push_tx(8'h20);
    wr(2'd0, 32'd2);
    chk("R2 ready stays", int'(ready), 1);
    chk("R2 no error", int'(err_cmdbusy), 0);
    repeat (4) @(negedge clk);
    chk("R2 tx untouched", txw - txr, 2);
    chk("R2 rx untouched", rxw - rxr, 0);
  endtask

  task automatic t_basic();
    logic [7:0] v [5];
    v = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    clear_fifos();
    wr(2'd2, 32'h8000_0000);
    chk("R2 enable set", int'(spi_en), 1);
    for (int i = 0; i < 5; i++) push_tx(v[i]);
    lat = 1;
    wr(2'd0, 32'h0000_3203);
    chk("R3 ready low", int'(ready), 0);
    chk("R3 active high", int'(active), 1);
    wait_ready();
    chk("R4 ready back", int'(ready), 1);
    chk("R3 active low at end", int'(active), 0);
    chk("R4 byte count", rxw - rxr, 3);
    for (int i = 0; i < 3; i++)
      chk("R1 rx byte", int'(rxmem[(rxr + i) & 15]), int'(v[i] ^ 8'hA5));
    chk("R6 tx flushed", txw - txr, 0);
    chk("R7 no stall", int'(tx_stall), 0);
  endtask

  task automatic t_busy();
    clear_fifos();
    for (int i = 0; i < 4; i++) push_tx(8'(8'hC0 + i));
    lat = 3;
    wr(2'd0, 32'd4);
    wr(2'd0, 32'd2);
    chk("R5 busy pulse", int'(err_cmdbusy), 1);
    @(negedge clk);
    chk("R5 pulse one cycle", int'(err_cmdbusy), 0);
    wait_ready();
    chk("R5 segment intact", rxw - rxr, 4);
    lat = 1;
  endtask

  task automatic t_txstall();
    clear_fifos();
    push_tx(8'h01); push_tx(8'h02);
    wr(2'd0, 32'd5);
    wait_ready();
    chk("R7 moved", rxw - rxr, 2);
    chk("R7 tx_stall", int'(tx_stall), 1);
    chk("R7 rx_stall", int'(rx_stall), 0);
    chk("R7 active low", int'(active), 0);
  endtask

  task automatic t_stall_clear();
    clear_fifos();
    push_tx(8'h5A);
    wr(2'd0, 32'd1);
    chk("R13 stall cleared", int'(tx_stall), 0);
    wait_ready();
    chk("R13 one byte", rxw - rxr, 1);
  endtask

  task automatic t_rxstall();
    clear_fifos();
    @(negedge clk); rx_fill_req = 1'b1;
    @(negedge clk); rx_fill_req = 1'b0;
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    wr(2'd0, 32'd5);
    wait_ready();
    chk("R8 rx filled", rxw - rxr, RXD);
    chk("R8 rx_stall", int'(rx_stall), 1);
    chk("R8 tx_stall", int'(tx_stall), 0);
    chk("R6 leftover dropped", txw - txr, 0);
  endtask

  task automatic t_zero();
    clear_fifos();
    push_tx(8'hAA); push_tx(8'hBB);
    wr(2'd0, 32'd0);
    chk("R9 active low", int'(active), 0);
    @(negedge clk);
    chk("R9 ready back", int'(ready), 1);
    chk("R9 no bytes", rxw - rxr, 0);
    chk("R9 tx flushed", txw - txr, 0);
  endtask

  task automatic t_csid();
    wr(2'd1, 32'd2);
    chk("R10 valid stored", int'(csid), 2);
    chk("R10 no error", int'(err_csidinval), 0);
    wr(2'd1, 32'd3);
    chk("R10 edge rejected", int'(err_csidinval), 1);
    chk("R10 csid kept", int'(csid), 2);
    wr(2'd1, 32'h100);
    chk("R10 wide rejected", int'(err_csidinval), 1);
    chk("R10 csid kept wide", int'(csid), 2);
  endtask

  task automatic t_swrst();
    clear_fifos();
    for (int i = 0; i < 6; i++) push_tx(8'(8'h70 + i));
    lat = 6;
    wr(2'd0, 32'd6);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'hC000_0000);
    chk("R11 ready", int'(ready), 1);
    chk("R11 active", int'(active), 0);
    chk("R11 spi_en", int'(spi_en), 0);
    chk("R11 csid", int'(csid), 0);
    chk("R11 flush pulses", int'({tx_flush, rx_flush}), 3);
    @(negedge clk);
    chk("R11 tx empty", txw - txr, 0);
    chk("R11 rx empty", rxw - rxr, 0);
    wr(2'd0, 32'd1);
    chk("R2 ignored after reset", int'(ready), 1);
    lat = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_busy();
    t_txstall();
    t_stall_clear();
    t_rxstall();
    t_zero();
    t_csid();
    t_swrst();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule